// File: doc/BRIEF.md
# Display FIFO with Diagnostic Register Access

This block is the 64-bit data FIFO that sits between a frame fetch engine and a display pipeline. In normal operation a fill port pushes whole 64-bit entries and a display-side port pops them. The head entry is always visible on the drain data output.

For test and bring-up, software can reach the same storage through one 32-bit register. The register is reached through a simple read and write strobe interface. The diagnostic path is honoured only while a diagnostic-enable input is high and a fill-load-enable input is low.

In the diagnostic path, two register writes build one entry. The first write supplies bits 31:0 and the second supplies bits 63:32. The entry is committed on the second write.

Register reads go through a 64-bit output latch. The first read of a session only loads the head entry into the latch, and the value it returns has no meaning. Each later read hands out one half, low half first. After the high half has been read, the read pointer advances and the next entry is reloaded. Every honoured read starts a four-clock busy window. Reads issued during that window are ignored.

Top module: `dispq_diag`

## Requirements
- R1: Register reads and writes take effect only when `diag_en` is 1 and `fill_en` is 0. At any other time they change neither the stored entries, the pointers, the half-word sequencing nor `busy`.
- R2: An honoured register write with even phase stores `reg_wdata` as bits 31:0 of a pending entry. The next honoured write supplies bits 63:32 and commits the entry at the tail. The write pointer advances once for each pair of writes.
- R3: The first honoured register read of a session does not move the read pointer. Its only effect is to load the head entry into the output latch, and the value seen on `reg_rdata` during that read carries no meaning.
- R4: After priming, `reg_rdata` shows bits 31:0 of the latched entry. A read of the low half shifts the latch so that bits 63:32 appear. A read of the high half pops the entry and loads the next entry into the latch. Entries come out in the order they were written.
- R5: Each honoured register read raises `busy` for exactly four clocks, starting at the edge where the read is taken. A read issued while `busy` is 1 leaves `reg_rdata` unchanged and does not advance the sequencing.
- R6: While `diag_en` is 0, the write phase, the read half, the priming state and the busy window are cleared. The next diagnostic session therefore starts with a low-half write and a priming read.
- R7: In normal mode, `fill_wr` with `fill_en` high pushes `fill_data`. `drain_rd` pops the head when the diagnostic path is not active. `drain_data` always shows the head entry, and entries drain in fill order.
- R8: `full` and `empty` track the occupancy of the FIFO. A push while full and a pop while empty are ignored. Pointers wrap modulo `DEPTH` (a power of two) and carry one extra bit to tell full from empty.
- R9: A diagnostic write pair that completes while the FIFO is full is discarded, and the stored contents stay as they were.
- R10: After reset, `empty` is 1, `full` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| diag_en | input | 1 | Diagnostic access enable; low clears diagnostic sequencing |
| fill_en | input | 1 | Fill-load enable; high selects normal fill mode |
| fill_wr | input | 1 | Push strobe for the fill port |
| fill_data | input | 64 | Entry to push |
| full | output | 1 | FIFO holds DEPTH entries |
| drain_rd | input | 1 | Pop strobe for the display-side port |
| drain_data | output | 64 | Current head entry |
| empty | output | 1 | FIFO holds no entry |
| reg_wr | input | 1 | Diagnostic register write strobe |
| reg_wdata | input | 32 | Diagnostic register write data |
| reg_rd | input | 1 | Diagnostic register read strobe |
| reg_rdata | output | 32 | Diagnostic register read data (low word of the output latch) |
| busy | output | 1 | Output latch shift in progress; reads are ignored |

## Verification
The hardest situation to reach from the ports is a session torn down in the middle of an entry. Such a session is broken either between the two halves of a write pair or after only the low half has been read back. Once it restarts, only the values returned afterwards show whether the phase and priming state were really cleared.

Directed sequences drop `diag_en` at exactly those points and then check what comes back. A re-primed read must return the same low half again, and a fresh pair must form an intact entry. The same directed sequences issue reads inside the busy window, fill the FIFO through register pairs until it is full, and mix random fill and drain traffic that wraps the pointers several times.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned HALF_W  = ENTRY_W / 2;
  typedef logic [ENTRY_W-1:0] entry_t;
  typedef logic [HALF_W-1:0]  half_t;
endpackage

// File: rtl/dfd_store.sv
module dfd_store
  import dfd_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  entry_t push_data,
  input  logic   pop,
  output entry_t head,
  output entry_t head_nxt,
  output logic   full,
  output logic   empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] PTR_ONE = 1;
  localparam logic [AW-1:0] IDX_ONE = 1;

  logic [AW:0]   wr_q, wr_d, rd_q, rd_d;
  logic [AW-1:0] nxt_idx;
  entry_t        mem [DEPTH];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = wr_q + PTR_ONE;
    if (pop)  rd_d = rd_q + PTR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_data;
  end

  assign nxt_idx  = rd_q[AW-1:0] + IDX_ONE;
  assign head     = mem[rd_q[AW-1:0]];
  assign head_nxt = mem[nxt_idx];
  assign empty    = (wr_q == rd_q);
  assign full     = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
endmodule

// File: rtl/dfd_wr_pack.sv
module dfd_wr_pack
  import dfd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   act,
  input  logic   clr,
  input  logic   wr,
  input  half_t  wdata,
  output logic   commit,
  output entry_t entry
);
  logic  phase_q, phase_d;
  logic  low_en;
  half_t low_q;

  assign low_en = act && wr && !phase_q;

  always_comb begin
    phase_d = phase_q;
    if (clr)            phase_d = 1'b0;
    else if (act && wr) phase_d = !phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk) begin
    if (low_en) low_q <= wdata;
  end

  assign commit = act && wr && phase_q;
  assign entry  = {wdata, low_q};
endmodule

// File: rtl/dfd_rd_unpack.sv
module dfd_rd_unpack
  import dfd_pkg::*;
#(
  parameter int unsigned SHIFT_CLKS = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   act,
  input  logic   clr,
  input  logic   rd,
  input  logic   empty,
  input  entry_t head,
  input  entry_t head_nxt,
  output logic   pop,
  output half_t  rdata,
  output logic   busy
);
  localparam int unsigned CW = $clog2(SHIFT_CLKS + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(SHIFT_CLKS);
  localparam logic [CW-1:0] CNT_ONE  = 1;

  logic          primed_q, primed_d;
  logic          half_q, half_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          take;
  entry_t        latch_q, latch_d;

  assign busy = (cnt_q != '0);
  assign take = act && rd && !busy;
  assign pop  = take && primed_q && half_q && !empty;

  always_comb begin
    primed_d = primed_q;
    half_d   = half_q;
    cnt_d    = cnt_q;
    latch_d  = latch_q;
    if (clr) begin
      primed_d = 1'b0;
      half_d   = 1'b0;
      cnt_d    = '0;
    end else begin
      if (busy) cnt_d = cnt_q - CNT_ONE;
      if (take) begin
        cnt_d = CNT_LOAD;
        if (!primed_q) begin
          primed_d = 1'b1;
          half_d   = 1'b0;
          latch_d  = head;
        end else if (!half_q) begin
          half_d  = 1'b1;
          latch_d = {{HALF_W{1'b0}}, latch_q[ENTRY_W-1:HALF_W]};
        end else begin
          half_d  = 1'b0;
          latch_d = head_nxt;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      half_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      primed_q <= primed_d;
      half_q   <= half_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take && !clr) latch_q <= latch_d;
  end

  assign rdata = latch_q[HALF_W-1:0];
endmodule

// File: rtl/dispq_diag.sv
module dispq_diag
  import dfd_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned SHIFT_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        diag_en,
  input  logic        fill_en,
  input  logic        fill_wr,
  input  logic [63:0] fill_data,
  output logic        full,
  input  logic        drain_rd,
  output logic [63:0] drain_data,
  output logic        empty,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        busy
);
  logic   diag_act, diag_clr;
  logic   pk_commit, rd_pop;
  logic   push, pop;
  entry_t pk_entry, push_data, head, head_nxt;

  assign diag_act = diag_en && !fill_en;
  assign diag_clr = !diag_en;

  dfd_wr_pack u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .act    (diag_act),
    .clr    (diag_clr),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .commit (pk_commit),
    .entry  (pk_entry)
  );

  dfd_rd_unpack #(.SHIFT_CLKS(SHIFT_CLKS)) u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (diag_act),
    .clr      (diag_clr),
    .rd       (reg_rd),
    .empty    (empty),
    .head     (head),
    .head_nxt (head_nxt),
    .pop      (rd_pop),
    .rdata    (reg_rdata),
    .busy     (busy)
  );

  always_comb begin
    push      = 1'b0;
    push_data = fill_data;
    if (fill_en) begin
      push = fill_wr && !full;
    end else if (diag_act) begin
      push      = pk_commit && !full;
      push_data = pk_entry;
    end
  end

  assign pop = diag_act ? rd_pop : (drain_rd && !empty);

  dfd_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (pop),
    .head      (head),
    .head_nxt  (head_nxt),
    .full      (full),
    .empty     (empty)
  );

  assign drain_data = head;
endmodule

// File: rtl/dispq_diag_chk.sv
module dispq_diag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        diag_en,
  input logic        fill_en,
  input logic        fill_wr,
  input logic [63:0] fill_data,
  input logic        full,
  input logic        drain_rd,
  input logic [63:0] drain_data,
  input logic        empty,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic        busy
);
  // R1
  inactive_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(diag_en && !fill_en) && !(fill_en && fill_wr) && !drain_rd)
      |=> ($stable(full) && $stable(empty)));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_en && !fill_en && reg_rd && !busy) |=> busy);

  // R5
  busy_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_en && !fill_en && reg_rd && busy) |=> $stable(reg_rdata));

  // R6
  clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en |=> !busy);

  // R8
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && fill_en && fill_wr && !drain_rd) |=> full);
endmodule

bind dispq_diag dispq_diag_chk u_chk (.*);

// File: tb/dispq_diag_bench.sv
`timescale 1ns/1ps
module dispq_diag_bench;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        diag_en, fill_en, fill_wr, drain_rd, reg_wr, reg_rd;
  logic [63:0] fill_data, drain_data;
  logic [31:0] reg_wdata, reg_rdata;
  logic        full, empty, busy;

  int tests, fails;
  logic [63:0] q[$];

  dispq_diag #(.DEPTH(DEPTH), .SHIFT_CLKS(4)) u_dispq_diag (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] lo_of(logic [63:0] e); return e[31:0]; endfunction
  function automatic logic [31:0] hi_of(logic [63:0] e); return e[63:32]; endfunction
  function automatic logic [63:0] rnd64(); return {$urandom, $urandom}; endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_push(logic [63:0] d);
    fill_wr = 1'b1; fill_data = d;
    @(negedge clk); fill_wr = 1'b0;
  endtask

  task automatic drain_pop();
    drain_rd = 1'b1;
    @(negedge clk); drain_rd = 1'b0;
  endtask

  task automatic reg_write(logic [31:0] w);
    reg_wr = 1'b1; reg_wdata = w;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(output logic [31:0] v);
    while (busy) @(negedge clk);
    reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic diag_write_entry(logic [63:0] e);
    reg_write(lo_of(e));
    reg_write(hi_of(e));
    if (q.size() < DEPTH) q.push_back(e);
  endtask

  task automatic diag_readback(string req);
    logic [31:0] v;
    reg_read(v); // priming read, value ignored
    while (q.size() > 0) begin
      logic [63:0] e = q.pop_front();
      reg_read(v); check({req, " low half"}, v, lo_of(e));
      reg_read(v); check({req, " high half"}, v, hi_of(e));
    end
    while (busy) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] e;
    void'($urandom(32'h5eed1234));
    tests = 0; fails = 0;
    rst_n = 1'b0; diag_en = 1'b0; fill_en = 1'b0; fill_wr = 1'b0; drain_rd = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; fill_data = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 empty", empty, 1);
    check("R10 full", full, 0);
    check("R10 busy", busy, 0);

    // R7 R8 normal fill then drain, push while full ignored
    fill_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin e = rnd64(); q.push_back(e); fill_push(e); end
    check("R8 full after DEPTH", full, 1);
    fill_push(64'hdead_beef_dead_beef);
    check("R8 push while full ignored", full, 1);
    fill_en = 1'b0;
    while (q.size() > 0) begin
      e = q.pop_front();
      check("R7 drain order", drain_data, e);
      drain_pop();
    end
    check("R8 empty after drain", empty, 1);
    drain_pop();
    check("R8 pop while empty ignored", empty, 1);

    // R7 R8 random traffic wrapping pointers
    fill_en = 1'b1;
    for (int i = 0; i < 400; i++) begin
      bit do_push = $urandom_range(0, 1) == 1;
      if (do_push) begin
        e = rnd64();
        if (q.size() < DEPTH) q.push_back(e);
        fill_push(e);
      end else begin
        if (q.size() > 0) begin
          check("R7 random drain head", drain_data, q[0]);
          void'(q.pop_front());
        end
        drain_pop();
      end
      check("R8 random empty flag", empty, q.size() == 0);
      check("R8 random full flag", full, q.size() == DEPTH);
    end
    fill_en = 1'b0;
    while (q.size() > 0) begin void'(q.pop_front()); drain_pop(); end

    // R1 register access ignored while fill_en high or diag_en low
    diag_en = 1'b1; fill_en = 1'b1;
    reg_write(32'h1111_1111); reg_write(32'h2222_2222);
    reg_rd = 1'b1; @(negedge clk); reg_rd = 1'b0;
    check("R1 busy idle with fill_en", busy, 0);
    fill_en = 1'b0;
    check("R1 no entry from gated writes", empty, 1);
    diag_en = 1'b0;
    reg_write(32'h3333_3333); reg_write(32'h4444_4444);
    reg_rd = 1'b1; @(negedge clk); reg_rd = 1'b0;
    check("R1 busy idle with diag off", busy, 0);
    check("R1 no entry with diag off", empty, 1);

    // R2 R3 R4 directed diagnostic session
    diag_en = 1'b1;
    diag_write_entry(64'h89ab_cdef_0123_4567);
    check("R2 one entry after pair", empty, 0);
    reg_write(32'haaaa_5555);
    check("R2 drain view unchanged mid-pair", drain_data, 64'h89ab_cdef_0123_4567);
    reg_write(32'h5555_aaaa);
    q.push_back(64'h5555_aaaa_aaaa_5555);
    reg_read(v);
    check("R3 priming keeps entries", empty, 0);
    // R5 busy window length
    for (int k = 0; k < 4; k++) check("R5 busy during window", busy, 1);
    while (0) ;
    begin
      int hi_cnt = 0;
      while (busy) begin hi_cnt++; @(negedge clk); end
      check("R5 busy length", hi_cnt, 4);
    end
    reg_read(v); check("R4 first low half", v, 32'h0123_4567);
    // R5 read during busy: unchanged and no advance
    reg_rd = 1'b1; #1 v2 = reg_rdata; @(negedge clk); reg_rd = 1'b0;
    check("R5 busy read value", v2, 32'h89ab_cdef);
    reg_read(v); check("R5 busy read no advance", v, 32'h89ab_cdef);
    void'(q.pop_front());
    reg_read(v); check("R4 second entry low", v, 32'haaaa_5555);
    reg_read(v); check("R4 second entry high", v, 32'h5555_aaaa);
    void'(q.pop_front());
    while (busy) @(negedge clk);
    check("R4 empty after readback", empty, 1);

    // R6 clear mid-pair and mid-read
    diag_en = 1'b0; @(negedge clk); diag_en = 1'b1;
    reg_write(32'hffff_0000);
    diag_en = 1'b0; @(negedge clk); diag_en = 1'b1;
    check("R6 half pair not committed", empty, 1);
    diag_write_entry(64'h7654_3210_fedc_ba98);
    reg_read(v);
    reg_read(v); check("R6 fresh pair low", v, 32'hfedc_ba98);
    diag_en = 1'b0; @(negedge clk);
    check("R6 busy cleared", busy, 0);
    diag_en = 1'b1;
    reg_read(v); // re-prime
    reg_read(v); check("R6 reprime low again", v, 32'hfedc_ba98);
    reg_read(v); check("R6 reprime high", v, 32'h7654_3210);
    void'(q.pop_front());
    while (busy) @(negedge clk);
    diag_en = 1'b0; @(negedge clk); diag_en = 1'b1;

    // R9 diagnostic fill to full with one extra pair, random data
    for (int i = 0; i < DEPTH + 1; i++) diag_write_entry(rnd64());
    check("R9 full after diag writes", full, 1);
    diag_readback("R9");
    check("R9 empty after readback", empty, 1);

    // R2 R4 random sessions
    for (int s = 0; s < 5; s++) begin
      diag_en = 1'b0; @(negedge clk); diag_en = 1'b1;
      for (int i = 0; i < $urandom_range(1, DEPTH); i++) diag_write_entry(rnd64());
      diag_readback("R4 random session");
      check("R2 random session drained", empty, 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule